// File: doc/BRIEF.md
# CAN Controller Interrupt Status Unit

This block gathers the interrupt sources of a CAN controller into one place. It samples the controller's internal status lines once per clock: bus-off and error-warning levels, transmit buffer free, data overrun, receive buffer message count, release-receive-buffer command, the two error counters, sleep mode and bus activity. From these it latches six interrupt flags into a status register. A mask register then reduces the flags to a single registered interrupt request line. The message buffers, bit engine and counter arithmetic stay outside; here they are only inputs.

Software reaches both registers through a plain one-cycle read/write port. The flags differ in how they are set and cleared. Most are set by an edge on a status line and cleared by writing 1. The wake-up flag is cleared by reading the status register. The receive flag follows the receive buffer through a three-state machine. RX_IDLE means there is no pending notice and the buffer is taken as empty. RX_NOTIFY means the flag is raised. RX_ACKED means software has cleared the flag by a write while messages still remain. The transitions are as follows. RX_IDLE goes to RX_NOTIFY when the count is non-zero. RX_NOTIFY goes to RX_IDLE on a release with at most one message left, or on a write-1 clear with an empty buffer. RX_NOTIFY goes to RX_ACKED on a write-1 clear while messages remain. RX_ACKED goes back to RX_NOTIFY on a release with more than one message. RX_ACKED goes to RX_IDLE on a release with at most one message, or when the count reads zero.

Top module: `can_irq_unit`

## Requirements
- R1: After reset the status register, the enable register, `reg_rdata` and `irq` are all zero.
- R2: Status bit 0 (receive) is raised when `rx_msg_count` becomes non-zero in RX_IDLE. A `rx_release` with `rx_msg_count` <= 1 clears it. A `rx_release` with `rx_msg_count` > 1 keeps it, or raises it again from RX_ACKED. Writing 1 to bit 0 clears it.
- R3: Status bit 1 (transmit) is set by a 0-to-1 transition of `tx_buf_free`. A steady high level does not set it again.
- R4: Status bit 2 (error warning) is set by any change, in either direction, of `bus_off` or `err_warn_lvl`.
- R5: Status bit 3 (overrun) is set only by a 0-to-1 transition of `data_overrun`. A 1-to-0 transition leaves it clear.
- R6: Status bit 4 (wake-up) is set in any cycle where `sleep_mode` and `bus_activity` are both high. A read of the status register clears it. Writes to the status register have no effect on it.
- R7: Status bit 5 (error passive) is set whenever the condition (`tx_err_cnt` > 127 or `rx_err_cnt` > 127) changes value, whether it rises or falls.
- R8: A write to offset 0x0C clears each of bits 0, 1, 2, 3 and 5 whose data bit is 1. A data bit of 0 leaves the flag unchanged. If a set event and a clear happen in the same cycle, the flag ends set.
- R9: The enable register at offset 0x10 holds bits 5:0, and bit n gates status bit n. `irq` is the registered OR of the enabled, set flags, so it follows a flag change one clock later.
- R10: A read returns its data on `reg_rdata` one clock after `reg_rd`. Offset 0x0C returns the status and 0x10 returns the enables. Bits 31:6 are always zero, and any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_off | input | 1 | Bus status level |
| err_warn_lvl | input | 1 | Error status level |
| tx_buf_free | input | 1 | Transmit buffer released level |
| data_overrun | input | 1 | Data overrun status level |
| rx_msg_count | input | MSG_CNT_W | Messages held in the receive buffer |
| rx_release | input | 1 | Release-receive-buffer command pulse |
| tx_err_cnt | input | ERR_CNT_W | Transmit error counter |
| rx_err_cnt | input | ERR_CNT_W | Receive error counter |
| sleep_mode | input | 1 | Controller is sleeping |
| bus_activity | input | 1 | Activity seen on the bus |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that every status input is held low during reset. This keeps the edge detectors and the sampled history used by the properties in agreement on the first cycle after reset. They also assume that `rx_msg_count` drops in the cycle after a release, as a real buffer would. The stimulus changes inputs only on the falling clock edge. It holds all lines at zero through reset. It lowers the message count one cycle after each release pulse. It never writes the status register in the first cycle after reset.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int FLAG_N = 6;

    localparam int F_RX   = 0;
    localparam int F_TX   = 1;
    localparam int F_EWRN = 2;
    localparam int F_OVR  = 3;
    localparam int F_WAKE = 4;
    localparam int F_EPAS = 5;

    localparam logic [FLAG_N-1:0] W1C_MASK = 6'b101111;
    localparam logic [FLAG_N-1:0] RC_MASK  = 6'b010000;

    localparam int STAT_OFS = 'h0C;
    localparam int EN_OFS   = 'h10;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_NOTIFY = 2'd1,
        RX_ACKED  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/can_irq_detect.sv
module can_irq_detect
    import can_irq_pkg::*;
#(
    parameter int ERR_CNT_W = 8,
    parameter int ERR_LIMIT = 127
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_off,
    input  logic                 err_warn_lvl,
    input  logic                 tx_buf_free,
    input  logic                 data_overrun,
    input  logic [ERR_CNT_W-1:0] tx_err_cnt,
    input  logic [ERR_CNT_W-1:0] rx_err_cnt,
    input  logic                 sleep_mode,
    input  logic                 bus_activity,
    output logic [FLAG_N-1:0]    set_evt
);
    localparam logic [ERR_CNT_W-1:0] LIMIT = ERR_CNT_W'(ERR_LIMIT);

    logic epas_cond;
    logic bus_off_q, ewrn_q, tx_q, ovr_q, epas_q;

    assign epas_cond = (tx_err_cnt > LIMIT) || (rx_err_cnt > LIMIT);

    // one register per sampled line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_off_q <= 1'b0;
            ewrn_q    <= 1'b0;
            tx_q      <= 1'b0;
            ovr_q     <= 1'b0;
            epas_q    <= 1'b0;
        end else begin
            bus_off_q <= bus_off;
            ewrn_q    <= err_warn_lvl;
            tx_q      <= tx_buf_free;
            ovr_q     <= data_overrun;
            epas_q    <= epas_cond;
        end
    end

    always_comb begin
        set_evt         = '0;
        set_evt[F_TX]   = tx_buf_free && !tx_q;
        set_evt[F_EWRN] = (bus_off ^ bus_off_q) || (err_warn_lvl ^ ewrn_q);
        set_evt[F_OVR]  = data_overrun && !ovr_q;
        set_evt[F_WAKE] = sleep_mode && bus_activity;
        set_evt[F_EPAS] = epas_cond ^ epas_q;
    end

endmodule

// File: rtl/can_irq_rxfsm.sv
module can_irq_rxfsm
    import can_irq_pkg::*;
#(
    parameter int MSG_CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MSG_CNT_W-1:0] rx_msg_count,
    input  logic                 rx_release,
    input  logic                 w1c,
    output logic                 rx_flag
);
    localparam logic [MSG_CNT_W-1:0] ONE = MSG_CNT_W'(1);

    rx_state_t state_q, state_d;
    logic      empty, more_left;

    assign empty     = (rx_msg_count == '0);
    assign more_left = (rx_msg_count > ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (!empty) state_d = RX_NOTIFY;
            end
            RX_NOTIFY: begin
                if (rx_release) state_d = more_left ? RX_NOTIFY : RX_IDLE;
                else if (w1c)   state_d = empty ? RX_IDLE : RX_ACKED;
            end
            RX_ACKED: begin
                if (rx_release) state_d = more_left ? RX_NOTIFY : RX_IDLE;
                else if (empty) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        rx_flag = (state_q == RX_NOTIFY);
    end

endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set_evt,
    input  logic [FLAG_N-1:0] clr_vec,
    input  logic              rx_flag,
    output logic [FLAG_N-1:0] status
);
    assign status[F_RX] = rx_flag;

    for (genvar i = 1; i < FLAG_N; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (set_evt[i]) flag_q <= 1'b1;   // set beats clear
            else if (clr_vec[i]) flag_q <= 1'b0;
        end
        assign status[i] = flag_q;
    end

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
    import can_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int MSG_CNT_W = 4,
    parameter int ERR_CNT_W = 8,
    parameter int ERR_LIMIT = 127
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_off,
    input  logic                 err_warn_lvl,
    input  logic                 tx_buf_free,
    input  logic                 data_overrun,
    input  logic [MSG_CNT_W-1:0] rx_msg_count,
    input  logic                 rx_release,
    input  logic [ERR_CNT_W-1:0] tx_err_cnt,
    input  logic [ERR_CNT_W-1:0] rx_err_cnt,
    input  logic                 sleep_mode,
    input  logic                 bus_activity,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFS);

    logic [FLAG_N-1:0] set_evt, clr_vec, status, enable;
    logic              hit_stat, hit_en, rx_flag, irq_q;
    logic [DATA_W-1:0] rdata_q;

    assign hit_stat = (reg_addr == A_STAT);
    assign hit_en   = (reg_addr == A_EN);

    assign clr_vec = ({FLAG_N{reg_wr && hit_stat}} & reg_wdata[FLAG_N-1:0] & W1C_MASK)
                   | ({FLAG_N{reg_rd && hit_stat}} & RC_MASK);

    can_irq_detect #(.ERR_CNT_W(ERR_CNT_W), .ERR_LIMIT(ERR_LIMIT)) u_detect (
        .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .err_warn_lvl(err_warn_lvl),
        .tx_buf_free(tx_buf_free), .data_overrun(data_overrun),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .sleep_mode(sleep_mode), .bus_activity(bus_activity), .set_evt(set_evt)
    );

    can_irq_rxfsm #(.MSG_CNT_W(MSG_CNT_W)) u_rxfsm (
        .clk(clk), .rst_n(rst_n), .rx_msg_count(rx_msg_count),
        .rx_release(rx_release), .w1c(clr_vec[F_RX]), .rx_flag(rx_flag)
    );

    can_irq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_vec(clr_vec),
        .rx_flag(rx_flag), .status(status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                enable <= '0;
        else if (reg_wr && hit_en) enable <= reg_wdata[FLAG_N-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= '0;
            if (hit_stat)    rdata_q[FLAG_N-1:0] <= status;
            else if (hit_en) rdata_q[FLAG_N-1:0] <= enable;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status & enable);
    end

    assign reg_rdata = rdata_q;
    assign irq       = irq_q;

endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk
    import can_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int MSG_CNT_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tx_buf_free,
    input logic                 data_overrun,
    input logic [MSG_CNT_W-1:0] rx_msg_count,
    input logic                 sleep_mode,
    input logic                 bus_activity,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 irq,
    input logic [FLAG_N-1:0]    status,
    input logic [FLAG_N-1:0]    enable
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    assert_rx_new_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_msg_count != '0 && $past(rx_msg_count) == '0) |=> status[F_RX]);

    assert_tx_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_buf_free) |=> status[F_TX]);

    assert_ovr_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_overrun) |=> status[F_OVR]);

    assert_wake_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STAT && !(sleep_mode && bus_activity)) |=> !status[F_WAKE]);

    assert_tx_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata[F_TX] && !$rose(tx_buf_free))
        |=> !status[F_TX]);

    assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & enable)) |=> irq);

    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & enable)) |=> !irq);

    assert_rdata_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:FLAG_N] == '0);

endmodule

bind can_irq_unit can_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MSG_CNT_W(MSG_CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_buf_free(tx_buf_free), .data_overrun(data_overrun),
    .rx_msg_count(rx_msg_count), .sleep_mode(sleep_mode), .bus_activity(bus_activity),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .status(status), .enable(enable)
);

// File: tb/sim_can_irq_unit.sv
`timescale 1ns/1ps
module sim_can_irq_unit;

    localparam logic [7:0] A_STAT = 8'h0C;
    localparam logic [7:0] A_EN   = 8'h10;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_off = 0, err_warn_lvl = 0, tx_buf_free = 0, data_overrun = 0;
    logic [3:0]  rx_msg_count = '0;
    logic        rx_release = 0;
    logic [7:0]  tx_err_cnt = '0, rx_err_cnt = '0;
    logic        sleep_mode = 0, bus_activity = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    bit    rd_seen = 0;
    item_t sb[$];

    always #5 clk = ~clk;

    can_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .err_warn_lvl(err_warn_lvl),
        .tx_buf_free(tx_buf_free), .data_overrun(data_overrun),
        .rx_msg_count(rx_msg_count), .rx_release(rx_release),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .sleep_mode(sleep_mode), .bus_activity(bus_activity),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // monitor: one scoreboard item per read strobe
    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            item_t it;
            n_cmp++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL read with empty scoreboard: got %h expected none", reg_rdata);
            end else begin
                it = sb.pop_front();
                if (reg_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(2);

        // R1 reset state
        chk_irq(0, "R1 irq after reset");
        n_cmp++;
        if (reg_rdata !== '0) begin
            n_bad++;
            $display("FAIL R1 rdata: got %h expected 0", reg_rdata);
        end
        rd(A_STAT, 32'h0, "R1 status after reset");
        rd(A_EN, 32'h0, "R1 enable after reset");

        // R3 transmit rise, R8 write-one clear
        tx_buf_free = 1; tick(1);
        rd(A_STAT, 32'h02, "R3 tx rise");
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h02, "R8 zero write keeps flag");
        wr(A_STAT, 32'h02);
        tick(2);
        rd(A_STAT, 32'h0, "R3 steady high no reset");

        // R5 overrun rise only
        data_overrun = 1; tick(1);
        rd(A_STAT, 32'h08, "R5 overrun rise");
        wr(A_STAT, 32'h08);
        data_overrun = 0; tick(2);
        rd(A_STAT, 32'h0, "R5 falling edge ignored");

        // R4 error warning on any change
        bus_off = 1; tick(1);
        rd(A_STAT, 32'h04, "R4 bus_off rise");
        wr(A_STAT, 32'h04);
        bus_off = 0; tick(1);
        rd(A_STAT, 32'h04, "R4 bus_off fall");
        wr(A_STAT, 32'h04);
        err_warn_lvl = 1; tick(1);
        rd(A_STAT, 32'h04, "R4 err_warn rise");
        wr(A_STAT, 32'h04);

        // R7 error passive crossings
        tx_err_cnt = 8'd128; tick(1);
        rd(A_STAT, 32'h20, "R7 tec above limit");
        wr(A_STAT, 32'h20);
        tx_err_cnt = 8'd127; tick(1);
        rd(A_STAT, 32'h20, "R7 back to active");
        wr(A_STAT, 32'h20);
        rx_err_cnt = 8'd200; tick(1);
        wr(A_STAT, 32'h20);
        tx_err_cnt = 8'd200; tick(2);
        rd(A_STAT, 32'h0, "R7 no event while condition holds");
        tx_err_cnt = 8'd0; rx_err_cnt = 8'd0; tick(1);
        rd(A_STAT, 32'h20, "R7 both counters drop");
        wr(A_STAT, 32'h20);

        // R6 wake-up, read clears, write does not
        sleep_mode = 1; bus_activity = 1; tick(1);
        sleep_mode = 0; bus_activity = 0;
        wr(A_STAT, 32'h10);
        rd(A_STAT, 32'h10, "R6 write does not clear wake");
        rd(A_STAT, 32'h0, "R6 read cleared wake");

        // R8 set wins over same-cycle clear
        tx_buf_free = 0; tick(1);
        tx_buf_free = 1;
        wr(A_STAT, 32'h02);
        rd(A_STAT, 32'h02, "R8 set beats clear");
        wr(A_STAT, 32'h02);

        // R9 enable gating and irq latency
        wr(A_EN, 32'h02);
        rd(A_EN, 32'h02, "R10 enable readback");
        tx_buf_free = 0; tick(1);
        tx_buf_free = 1; tick(1);
        chk_irq(0, "R9 irq one cycle after flag");
        tick(1);
        chk_irq(1, "R9 irq asserted");
        wr(A_STAT, 32'h02);
        chk_irq(1, "R9 irq lags clear");
        tick(1);
        chk_irq(0, "R9 irq dropped");
        data_overrun = 1; tick(3);
        chk_irq(0, "R9 masked flag no irq");
        rd(A_STAT, 32'h08, "R9 masked flag still latched");
        wr(A_STAT, 32'h08);
        data_overrun = 0;

        // R2 receive state machine
        rx_msg_count = 4'd1; tick(1);
        rd(A_STAT, 32'h01, "R2 message arrives");
        rx_release = 1; tick(1);
        rx_release = 0; rx_msg_count = 4'd0; tick(1);
        rd(A_STAT, 32'h0, "R2 release last message");
        rx_msg_count = 4'd2; tick(1);
        wr(A_STAT, 32'h01);
        rd(A_STAT, 32'h0, "R2 write-one clear with messages left");
        rx_release = 1; tick(1);
        rx_release = 0; rx_msg_count = 4'd1;
        rd(A_STAT, 32'h01, "R2 release with more re-raises");
        rx_release = 1; tick(1);
        rx_release = 0; rx_msg_count = 4'd0; tick(1);
        rd(A_STAT, 32'h0, "R2 final release clears");

        // R10 upper bits and unmapped offset
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, 32'h3F, "R10 enable upper bits zero");
        rd(8'h04, 32'h0, "R10 unmapped offset");
        chk_irq(0, "R9 all enabled, nothing set");

        tick(2);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d left expected 0", sb.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule